// File: doc/BRIEF.md
# Byte-Loadable Four-Channel DAC Input Bank

This block is the digital loading path in front of a four-channel, 14-bit digital-to-analog converter. A host on a parallel bus addresses one of the channel input registers and writes it either as one full 14-bit word or as two right-justified pieces: an 8-bit low part and a 6-bit high part. Each channel also has an output latch that holds the code the converter actually uses. The load strobe moves the staged input registers into the latches, either all at once on its release or continuously while it is held active. An asynchronous clear forces every latch to mid-scale.

All bus strobes are sampled by the block clock. A write takes effect on the clock edge that first sees the write strobe high after it was low, provided chip select is low at that edge. The input registers and latches both start at mid-scale after reset.

Top module: `dac_bank_loader`

## Requirements
- R1: After reset (rst_n low), every input register and every output latch holds 14'h2000, and the latches show 14'h2000 until a load.
- R2: With cs_n low, a clock edge that sees wr_n high after seeing it low the edge before writes data[13:0] into the input register chosen by addr when byte_mode is 0.
- R3: With byte_mode 1 and byte_hi 0, a write replaces bits 7:0 of the selected input register with data[7:0] and leaves bits 13:8 unchanged.
- R4: With byte_mode 1 and byte_hi 1, a write replaces bits 13:8 of the selected input register with data[5:0] (right-justified on the bus) and leaves bits 7:0 unchanged; data[13:6] is ignored.
- R5: A write strobe edge seen while cs_n is high changes no input register.
- R6: Writes with addr 4 to 7 change no input register; addr 0 to 3 select channels 0 to 3.
- R7: While ldac_n is high and stays high, the latches keep their values whatever is written to the input registers.
- R8: While ldac_n is low, each latch takes its input register value at every clock edge, so a write shows on dac_q one clock edge after the edge that stored it.
- R9: The edge that first sees ldac_n high after low loads all four latches together from the input registers.
- R10: clr_n low forces all latches to 14'h2000 at once without waiting for a clock and holds them there even with ldac_n low; input registers are not cleared and can be loaded afterwards.
- R11: Channel n's latch appears on dac_q[14*n+13:14*n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low power-on reset to mid-scale |
| clr_n | input | 1 | Active-low asynchronous clear of the output latches |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Write strobe; its low-to-high transition commits the write |
| ldac_n | input | 1 | Active-low load strobe for the output latches |
| byte_mode | input | 1 | 0 = full word write, 1 = partial write |
| byte_hi | input | 1 | In partial writes: 0 = low 8 bits, 1 = high 6 bits |
| addr | input | 3 | Channel address; 0 to 3 valid |
| data | input | 14 | Write data, right-justified |
| dac_q | output | 56 | Four 14-bit latch values, channel 0 in the low bits |

## Verification
On every cycle the assertions check that at most one channel is written and that nothing is written for an unselected chip or an address above 3, that partial writes keep the untouched bits of the register, that a latch holds whenever no load is requested and takes the staged value one edge after a load, and that clear pins the latches to mid-scale. Only the bench's scenarios can show the end-to-end results: that the merged value from a low and a high partial write arrives at the right slice of dac_q, that a load after many unrelated writes brings out exactly the last value staged per channel, that clear acts with no clock edge, and that staged data survives a clear.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  localparam int unsigned CODE_W   = 14;
  localparam int unsigned LOW_W    = 8;
  localparam int unsigned HIGH_W   = CODE_W - LOW_W;
  localparam logic [CODE_W-1:0] MID_CODE = 14'h2000;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    WR_FULL = 2'd0,
    WR_LOW  = 2'd1,
    WR_HIGH = 2'd2
  } wr_kind_e;

  // Classify a bus write from the two mode inputs.
  function automatic wr_kind_e classify(input logic byte_mode, input logic byte_hi);
    if (!byte_mode) return WR_FULL;
    return byte_hi ? WR_HIGH : WR_LOW;
  endfunction

  // New register value after a write of the given kind.
  function automatic code_t merge_write(input code_t old_val, input code_t bus,
                                        input wr_kind_e kind);
    code_t r;
    r = old_val;
    case (kind)
      WR_FULL: r = bus;
      WR_LOW:  r[LOW_W-1:0] = bus[LOW_W-1:0];
      WR_HIGH: r[CODE_W-1:LOW_W] = bus[HIGH_W-1:0];
      default: r = old_val;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dac_bank_decode.sv
module dac_bank_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ldac_n,
  input  logic [AW-1:0]     addr,
  output logic              wr_evt,
  output logic [NUM_CH-1:0] ch_we,
  output logic              load_en
);

  logic wr_n_q;
  logic ldac_n_q;
  logic addr_ok;
  logic ldac_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q   <= 1'b1;
      ldac_n_q <= 1'b1;
    end else begin
      wr_n_q   <= wr_n;
      ldac_n_q <= ldac_n;
    end
  end

  // Commit point: strobe seen high after low, chip selected.
  assign wr_evt    = wr_n & ~wr_n_q & ~cs_n;
  assign addr_ok   = (32'(addr) < NUM_CH);
  assign ldac_rise = ldac_n & ~ldac_n_q;
  assign load_en   = ~ldac_n | ldac_rise;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_we[i] = wr_evt & addr_ok & (addr == AW'(i));
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_we)); // R6

  AST_BAD_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(addr) >= NUM_CH) |-> (ch_we == '0)); // R6

  AST_NO_CS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ch_we == '0)); // R5

endmodule

// File: rtl/dac_in_reg.sv
module dac_in_reg
  import dac_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  logic  byte_mode,
  input  logic  byte_hi,
  input  code_t data,
  output code_t q
);

  wr_kind_e kind;
  code_t    next_val;

  assign kind     = classify(byte_mode, byte_hi);
  assign next_val = merge_write(q, data, kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= MID_CODE;
    else if (we) q <= next_val;
  end

  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == WR_LOW) |=> (q[CODE_W-1:LOW_W] == $past(q[CODE_W-1:LOW_W]))); // R3

  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == WR_HIGH) |=> (q[LOW_W-1:0] == $past(q[LOW_W-1:0]))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R5

  AST_FULL_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == WR_FULL) |=> (q == $past(data))); // R2

endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch
  import dac_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_n,
  input  logic  load,
  input  code_t d,
  output code_t q
);

  logic clear_n;
  assign clear_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)  q <= MID_CODE;
    else if (load) q <= d;
  end

  AST_CLEAR_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (q == MID_CODE)); // R10

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load |=> (q == $past(d))); // R8

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !load |=> $stable(q)); // R7

endmodule

// File: rtl/dac_bank_loader.sv
module dac_bank_loader
  import dac_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned AW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n,
  input  logic                     cs_n,
  input  logic                     wr_n,
  input  logic                     ldac_n,
  input  logic                     byte_mode,
  input  logic                     byte_hi,
  input  logic [AW-1:0]            addr,
  input  logic [CODE_W-1:0]        data,
  output logic [NUM_CH*CODE_W-1:0] dac_q
);

  logic              wr_evt;
  logic [NUM_CH-1:0] ch_we;
  logic              load_en;
  code_t             stage_q [NUM_CH];
  code_t             latch_q [NUM_CH];

  dac_bank_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .ldac_n  (ldac_n),
    .addr    (addr),
    .wr_evt  (wr_evt),
    .ch_we   (ch_we),
    .load_en (load_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_in_reg u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ch_we[c]),
      .byte_mode (byte_mode),
      .byte_hi   (byte_hi),
      .data      (data),
      .q         (stage_q[c])
    );

    dac_out_latch u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_n (clr_n),
      .load  (load_en),
      .d     (stage_q[c]),
      .q     (latch_q[c])
    );

    assign dac_q[c*CODE_W +: CODE_W] = latch_q[c];
  end

  AST_WRITE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_we != '0) |-> wr_evt); // R2

  AST_RESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (latch_q[0] == MID_CODE)); // R1

endmodule

// File: tb/dac_bank_loader_tb.sv
module dac_bank_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n, clr_n, cs_n, wr_n, ldac_n, byte_mode, byte_hi;
  logic [2:0]  addr;
  logic [13:0] data;
  logic [55:0] dac_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [13:0] m_in  [4];
  logic [13:0] m_lat [4];

  always #4 clk = ~clk;

  dac_bank_loader u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .ldac_n(ldac_n), .byte_mode(byte_mode), .byte_hi(byte_hi),
    .addr(addr), .data(data), .dac_q(dac_q)
  );

  function automatic logic [13:0] exp_merge(input logic [13:0] old_v, input logic [13:0] d,
                                            input logic bm, input logic bh);
    logic [13:0] keep_mask, new_bits;
    if (!bm) begin keep_mask = 14'h0000; new_bits = d; end
    else if (!bh) begin keep_mask = 14'h3F00; new_bits = {6'h00, d[7:0]}; end
    else begin keep_mask = 14'h00FF; new_bits = {d[5:0], 8'h00}; end
    return (old_v & keep_mask) | (new_bits & ~keep_mask);
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) check(req, dac_q[c*14 +: 14], m_lat[c]);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [13:0] d,
                          input logic bm, input logic bh, input logic csn);
    @(negedge clk);
    cs_n = csn; addr = a; data = d; byte_mode = bm; byte_hi = bh; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    if (!csn && a < 3'd4) m_in[a] = exp_merge(m_in[a], d, bm, bh);
  endtask

  task automatic pulse_ldac;
    @(negedge clk); ldac_n = 1'b0;
    @(negedge clk); ldac_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) m_lat[c] = m_in[c];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; clr_n = 1; cs_n = 1; wr_n = 1; ldac_n = 1;
    byte_mode = 0; byte_hi = 0; addr = 0; data = 0;
    for (int c = 0; c < 4; c++) begin m_in[c] = 14'h2000; m_lat[c] = 14'h2000; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 latches after reset");
    pulse_ldac();
    check_all("R1 input registers after reset");

    // R2 full words, held off by ldac_n high (R7)
    do_write(3'd0, 14'h1234, 0, 0, 0);
    do_write(3'd1, 14'h3FFF, 0, 0, 0);
    do_write(3'd2, 14'h0000, 0, 0, 0);
    do_write(3'd3, 14'h0ABC, 0, 0, 0);
    check_all("R7 hold while ldac_n high");
    pulse_ldac();
    check_all("R9 R2 R11 simultaneous load");

    // R3 low part then R4 high part with junk above bit 5
    do_write(3'd2, 14'h3FA5, 1, 0, 0);
    pulse_ldac();
    check("R3 low byte merge", dac_q[28 +: 14], 14'h00A5);
    do_write(3'd2, 14'h3F3C, 1, 1, 0);
    pulse_ldac();
    check("R4 high byte right-justified", dac_q[28 +: 14], 14'h3CA5);

    // R5 chip not selected
    do_write(3'd0, 14'h0001, 0, 0, 1);
    pulse_ldac();
    check("R5 write ignored without cs", dac_q[0 +: 14], 14'h1234);

    // R6 addresses 4..7
    for (int a = 4; a < 8; a++) do_write(3'(a), 14'h1111, 0, 0, 0);
    pulse_ldac();
    check_all("R6 high addresses ignored");

    // R8 transparent load, cycle exact
    @(negedge clk); ldac_n = 1'b0;
    @(negedge clk);
    cs_n = 0; addr = 3'd1; data = 14'h0777; byte_mode = 0; byte_hi = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
    check("R8 latch one edge behind store", dac_q[14 +: 14], 14'h3FFF);
    @(negedge clk);
    check("R8 latch follows input register", dac_q[14 +: 14], 14'h0777);
    m_in[1] = 14'h0777; m_lat[1] = 14'h0777;
    ldac_n = 1'b1;
    @(negedge clk);

    // R10 asynchronous clear
    do_write(3'd3, 14'h1E1E, 0, 0, 0);
    @(negedge clk); clr_n = 1'b0;
    #1;
    for (int c = 0; c < 4; c++) check("R10 async clear", dac_q[c*14 +: 14], 14'h2000);
    ldac_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4; c++) check("R10 clear beats load", dac_q[c*14 +: 14], 14'h2000);
    ldac_n = 1'b1;
    @(negedge clk); clr_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4; c++) check("R10 stays clear after release", dac_q[c*14 +: 14], 14'h2000);
    pulse_ldac();
    check_all("R10 staged data survives clear");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 6) begin
        do_write(3'($urandom % 8), 14'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 6) == 0);
      end else if (op == 6) begin
        pulse_ldac();
        check_all("R9 random load");
      end else begin
        check_all("R7 random hold");
      end
    end
    pulse_ldac();
    check_all("R11 final channel slices");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule